// File: doc/BRIEF.md
# Radio control state sequencer

This block is the main control state machine for the transmit side of a packet radio. It takes single-cycle command pulses (reset, start transmit, return to idle, flush the transmit FIFO) and walks the radio through its start-up phases. When transmit is requested from idle, it can run a calibration phase and a fixed-length bandwidth-boost phase first, depending on a 2-bit auto-calibration setting. It then waits in a synthesizer phase until the frequency synthesizer reports lock, and only then enters transmit. If the transmit FIFO runs dry during transmission, the machine parks in an underflow state. Only an idle or flush command releases it from there.

The analog synthesizer, the calibration engine and the FIFO are outside this block and appear only as level inputs. The current state is presented as an 8-bit readable code and as a 3-bit coarse code meant for a status byte. A one-cycle `fifo_flush` pulse tells the FIFO to empty itself whenever a flush command is accepted. All outputs are registered. Each output changes one clock edge after the input that causes the change.

Top module: `radio_ctl_seq`

## Requirements
- R1: `state_code` uses the codes idle 0x01, calibrate 0x08, bandwidth boost 0x09, synthesizer 0x0A, transmit 0x13 and underflow 0x16. After `rst` it reads 0x01, with `status_state` = 000 and `fifo_flush` = 0.
- R2: A transmit strobe in idle with `autocal_mode` = 01 enters calibrate at the next edge. Calibrate is held while `cal_done` is low and moves to bandwidth boost on the edge where `cal_done` is high.
- R3: Bandwidth boost lasts exactly BOOST_CYCLES clock cycles, then moves to synthesizer.
- R4: A transmit strobe in idle with `autocal_mode` equal to 00, 10 or 11 goes straight to synthesizer, skipping calibrate and bandwidth boost.
- R5: Synthesizer is held while `lock_det` is low and moves to transmit on the edge where `lock_det` is high. Transmit is held while `fifo_empty` is low.
- R6: In transmit, a high `fifo_empty` moves to underflow. Underflow is held regardless of `fifo_empty` and transmit strobes, and is left only by an idle, reset or flush strobe.
- R7: A flush strobe is honoured only in idle or underflow. It then ends in idle with `fifo_flush` high for exactly one cycle. In any other state the strobe is ignored: no pulse, and sequencing continues as if it were absent.
- R8: An idle strobe returns to idle at the next edge from every state.
- R9: A reset strobe returns to idle at the next edge from every state. When several strobes coincide, priority is reset, then idle, then flush, then transmit. An idle strobe therefore suppresses a coinciding flush pulse, and a flush in idle suppresses a coinciding transmit.
- R10: `status_state` is 000 in idle, 100 in calibrate and bandwidth boost, 011 in synthesizer, 010 in transmit and 111 in underflow, and always tracks `state_code` in the same cycle.
- R11: A transmit strobe outside idle has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strb_reset | input | 1 | Reset command pulse |
| strb_idle | input | 1 | Return-to-idle command pulse |
| strb_flush | input | 1 | Flush-transmit-FIFO command pulse |
| strb_xmit | input | 1 | Start-transmit command pulse |
| cal_done | input | 1 | Calibration engine finished |
| lock_det | input | 1 | Synthesizer lock detected |
| fifo_empty | input | 1 | Transmit FIFO has run empty |
| autocal_mode | input | 2 | Auto-calibration setting; 01 enables calibration on start |
| state_code | output | 8 | Registered readable state code |
| status_state | output | 3 | Registered coarse state for the status byte |
| fifo_flush | output | 1 | One-cycle pulse when a flush is accepted |

## Verification
The bench counts the bandwidth-boost cycles exactly. A timer that is off by one shows up as synthesizer appearing one cycle early or one cycle late. A flush strobe is issued in calibrate and in transmit, where it must be ignored. A design that gates it wrongly would drop the machine to idle or emit a spurious `fifo_flush` pulse. Coinciding strobes are applied to check the priority order: a design that ranks flush above idle pulses `fifo_flush` when it should not, and one that ranks transmit above flush leaves idle. The underflow state is hit with a deasserted empty flag and a transmit strobe, and a leaky design would slip back into transmit.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

  // Readable state codes; the values are the externally visible encoding.
  typedef enum logic [7:0] {
    RS_IDLE    = 8'h01,
    RS_CAL     = 8'h08,
    RS_BOOST   = 8'h09,
    RS_SYNTH   = 8'h0A,
    RS_XMIT    = 8'h13,
    RS_STARVED = 8'h16
  } rs_state_e;

  // Arbitrated command, one per cycle.
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_RESET,
    CMD_IDLE,
    CMD_FLUSH,
    CMD_XMIT
  } rs_cmd_e;

  // Strobe vector bit positions; the lowest index has the highest priority.
  localparam int unsigned STB_RESET = 0;
  localparam int unsigned STB_IDLE  = 1;
  localparam int unsigned STB_FLUSH = 2;
  localparam int unsigned STB_XMIT  = 3;
  localparam int unsigned STB_COUNT = 4;

  localparam logic [1:0] AUTOCAL_ON_START = 2'b01;

  localparam logic [2:0] COARSE_IDLE    = 3'b000;
  localparam logic [2:0] COARSE_XMIT    = 3'b010;
  localparam logic [2:0] COARSE_CAL     = 3'b100;
  localparam logic [2:0] COARSE_SYNTH   = 3'b011;
  localparam logic [2:0] COARSE_STARVED = 3'b111;

endpackage

// File: rtl/rs_strobe_arb.sv
module rs_strobe_arb
  import radio_seq_pkg::*;
(
  input  logic [STB_COUNT-1:0] strobes,
  output rs_cmd_e              cmd
);

  // Later assignments override earlier ones, so the lowest index wins.
  always_comb begin
    cmd = CMD_NONE;
    if (strobes[STB_XMIT])  cmd = CMD_XMIT;
    if (strobes[STB_FLUSH]) cmd = CMD_FLUSH;
    if (strobes[STB_IDLE])  cmd = CMD_IDLE;
    if (strobes[STB_RESET]) cmd = CMD_RESET;
  end

endmodule

// File: rtl/rs_boost_timer.sv
module rs_boost_timer #(
  parameter int unsigned BOOST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic expired
);

  localparam int unsigned CW = (BOOST_CYCLES > 1) ? $clog2(BOOST_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BOOST_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // Count only while the boost phase is active; restart from zero otherwise.
  always_ff @(posedge clk) begin
    if (rst || !active) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = active && (cnt_q == LAST);

  // The core must leave the boost phase once the timer reports expiry.
  AST_BOOST_LEAVES: assert property (@(posedge clk) disable iff (rst)
    expired |=> !active); // R3

endmodule

// File: rtl/rs_status_enc.sv
module rs_status_enc
  import radio_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rs_state_e state_d,
  output logic [2:0] coarse_q
);

  logic [2:0] coarse_d;

  // Map the next state so the coarse code lines up with the state register.
  always_comb begin
    unique case (state_d)
      RS_CAL, RS_BOOST: coarse_d = COARSE_CAL;
      RS_SYNTH:         coarse_d = COARSE_SYNTH;
      RS_XMIT:          coarse_d = COARSE_XMIT;
      RS_STARVED:       coarse_d = COARSE_STARVED;
      default:          coarse_d = COARSE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) coarse_q <= COARSE_IDLE;
    else     coarse_q <= coarse_d;
  end

endmodule

// File: rtl/rs_state_core.sv
module rs_state_core
  import radio_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rs_cmd_e    cmd,
  input  logic       cal_done,
  input  logic       lock_det,
  input  logic       fifo_empty,
  input  logic [1:0] autocal_mode,
  input  logic       boost_expired,
  output rs_state_e  state_q,
  output rs_state_e  state_d,
  output logic       flush_q
);

  logic flush_d;
  logic flush_ok;
  logic past_ok;

  assign flush_ok = (cmd == CMD_FLUSH) &&
                    ((state_q == RS_IDLE) || (state_q == RS_STARVED));

  always_comb begin
    state_d = state_q;
    flush_d = 1'b0;
    if (cmd == CMD_RESET || cmd == CMD_IDLE) begin
      state_d = RS_IDLE;
    end else if (flush_ok) begin
      state_d = RS_IDLE;
      flush_d = 1'b1;
    end else begin
      // A flush outside idle/underflow falls through here unchanged.
      case (state_q)
        RS_IDLE:
          if (cmd == CMD_XMIT)
            state_d = (autocal_mode == AUTOCAL_ON_START) ? RS_CAL : RS_SYNTH;
        RS_CAL:     if (cal_done)      state_d = RS_BOOST;
        RS_BOOST:   if (boost_expired) state_d = RS_SYNTH;
        RS_SYNTH:   if (lock_det)      state_d = RS_XMIT;
        RS_XMIT:    if (fifo_empty)    state_d = RS_STARVED;
        RS_STARVED: state_d = RS_STARVED;
        default:    state_d = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RS_IDLE;
      flush_q <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      state_q <= state_d;
      flush_q <= flush_d;
      past_ok <= 1'b1;
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (state_q inside {RS_IDLE, RS_CAL, RS_BOOST, RS_SYNTH, RS_XMIT, RS_STARVED})); // R1

  AST_BOOST_FROM_CAL: assert property (@(posedge clk) disable iff (rst)
    (past_ok && state_q == RS_BOOST && $past(state_q) != RS_BOOST) |-> $past(state_q) == RS_CAL); // R2

  AST_XMIT_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    (past_ok && state_q == RS_XMIT && $past(state_q) != RS_XMIT)
      |-> ($past(state_q) == RS_SYNTH && $past(lock_det))); // R5

  AST_STARVED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(state_q) == RS_STARVED && ($past(cmd) == CMD_NONE || $past(cmd) == CMD_XMIT))
      |-> state_q == RS_STARVED); // R6

  AST_FLUSH_GATED: assert property (@(posedge clk) disable iff (rst)
    (past_ok && flush_q)
      |-> (($past(state_q) == RS_IDLE || $past(state_q) == RS_STARVED) && state_q == RS_IDLE)); // R7

endmodule

// File: rtl/radio_ctl_seq.sv
module radio_ctl_seq
  import radio_seq_pkg::*;
#(
  parameter int unsigned BOOST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strb_reset,
  input  logic       strb_idle,
  input  logic       strb_flush,
  input  logic       strb_xmit,
  input  logic       cal_done,
  input  logic       lock_det,
  input  logic       fifo_empty,
  input  logic [1:0] autocal_mode,
  output logic [7:0] state_code,
  output logic [2:0] status_state,
  output logic       fifo_flush
);

  logic [STB_COUNT-1:0] strobes;
  rs_cmd_e   cmd;
  rs_state_e state_q;
  rs_state_e state_d;
  logic      boost_expired;
  logic      boost_active;

  always_comb begin
    strobes            = '0;
    strobes[STB_RESET] = strb_reset;
    strobes[STB_IDLE]  = strb_idle;
    strobes[STB_FLUSH] = strb_flush;
    strobes[STB_XMIT]  = strb_xmit;
  end

  rs_strobe_arb u_arb (
    .strobes (strobes),
    .cmd     (cmd)
  );

  assign boost_active = (state_q == RS_BOOST);

  rs_boost_timer #(.BOOST_CYCLES(BOOST_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .active  (boost_active),
    .expired (boost_expired)
  );

  rs_state_core u_core (
    .clk           (clk),
    .rst           (rst),
    .cmd           (cmd),
    .cal_done      (cal_done),
    .lock_det      (lock_det),
    .fifo_empty    (fifo_empty),
    .autocal_mode  (autocal_mode),
    .boost_expired (boost_expired),
    .state_q       (state_q),
    .state_d       (state_d),
    .flush_q       (fifo_flush)
  );

  rs_status_enc u_status (
    .clk      (clk),
    .rst      (rst),
    .state_d  (state_d),
    .coarse_q (status_state)
  );

  assign state_code = state_q;

  AST_RESET_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
    strb_reset |=> state_code == 8'h01); // R9

  AST_IDLE_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
    strb_idle |=> (state_code == 8'h01 && !fifo_flush)); // R8

  AST_XMIT_OUTSIDE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (strb_xmit && !strb_reset && !strb_idle && !strb_flush &&
     state_code == 8'h16) |=> state_code == 8'h16); // R11

endmodule

// File: tb/test_radio_ctl_seq.sv
`timescale 1ns/1ps
module test_radio_ctl_seq;

  localparam int BOOST = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strb_reset = 1'b0;
  logic       strb_idle = 1'b0;
  logic       strb_flush = 1'b0;
  logic       strb_xmit = 1'b0;
  logic       cal_done = 1'b0;
  logic       lock_det = 1'b0;
  logic       fifo_empty = 1'b0;
  logic [1:0] autocal_mode = 2'b00;
  logic [7:0] state_code;
  logic [2:0] status_state;
  logic       fifo_flush;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  radio_ctl_seq #(.BOOST_CYCLES(BOOST)) i_radio_ctl_seq (
    .clk          (clk),
    .rst          (rst),
    .strb_reset   (strb_reset),
    .strb_idle    (strb_idle),
    .strb_flush   (strb_flush),
    .strb_xmit    (strb_xmit),
    .cal_done     (cal_done),
    .lock_det     (lock_det),
    .fifo_empty   (fifo_empty),
    .autocal_mode (autocal_mode),
    .state_code   (state_code),
    .status_state (status_state),
    .fifo_flush   (fifo_flush)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic fire(input logic r, input logic i, input logic f, input logic t);
    strb_reset = r; strb_idle = i; strb_flush = f; strb_xmit = t;
    @(negedge clk);
    strb_reset = 0; strb_idle = 0; strb_flush = 0; strb_xmit = 0;
  endtask

  task automatic go_synth(input logic [1:0] ac);
    autocal_mode = ac;
    fire(0, 0, 0, 1);
  endtask

  task automatic go_xmit();
    go_synth(2'b00);
    lock_det = 1; step(); lock_det = 0;
  endtask

  task automatic go_starved();
    go_xmit();
    fifo_empty = 1; step(); fifo_empty = 0;
  endtask

  task automatic t_reset_state();
    chk("R1 reset code", state_code, 8'h01);
    chk("R1 reset status", status_state, 3'b000);
    chk("R1 reset flush", fifo_flush, 0);
  endtask

  task automatic t_cal_path();
    autocal_mode = 2'b01;
    fire(0, 0, 0, 1);
    chk("R2 enter cal", state_code, 8'h08);
    chk("R10 cal status", status_state, 3'b100);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R2 hold cal", state_code, 8'h08);
    end
    fire(0, 0, 0, 1);
    chk("R11 xmit in cal", state_code, 8'h08);
    fire(0, 0, 1, 0);
    chk("R7 flush in cal code", state_code, 8'h08);
    chk("R7 flush in cal pulse", fifo_flush, 0);
    cal_done = 1; step(); cal_done = 0;
    chk("R2 cal to boost", state_code, 8'h09);
    chk("R10 boost status", status_state, 3'b100);
    for (int k = 1; k < BOOST; k++) begin
      step();
      chk("R3 boost length", state_code, 8'h09);
    end
    step();
    chk("R3 boost to synth", state_code, 8'h0A);
    chk("R10 synth status", status_state, 3'b011);
    step(); step();
    chk("R5 hold synth", state_code, 8'h0A);
    lock_det = 1; step(); lock_det = 0;
    chk("R5 lock to xmit", state_code, 8'h13);
    chk("R10 xmit status", status_state, 3'b010);
    step();
    chk("R5 hold xmit", state_code, 8'h13);
    fifo_empty = 1; step(); fifo_empty = 0;
    chk("R6 underflow", state_code, 8'h16);
    chk("R10 underflow status", status_state, 3'b111);
    step();
    chk("R6 hold underflow", state_code, 8'h16);
    fire(0, 0, 0, 1);
    chk("R6 xmit in underflow", state_code, 8'h16);
    fire(0, 0, 1, 0);
    chk("R7 flush underflow code", state_code, 8'h01);
    chk("R7 flush underflow pulse", fifo_flush, 1);
    step();
    chk("R7 pulse one cycle", fifo_flush, 0);
  endtask

  task automatic t_skip_cal();
    logic [1:0] modes [3] = '{2'b00, 2'b10, 2'b11};
    for (int k = 0; k < 3; k++) begin
      go_synth(modes[k]);
      chk("R4 skip cal", state_code, 8'h0A);
      fire(0, 1, 0, 0);
      chk("R8 idle from synth", state_code, 8'h01);
    end
  endtask

  task automatic t_idle_abort();
    autocal_mode = 2'b01; fire(0, 0, 0, 1);
    fire(0, 1, 0, 0);
    chk("R8 idle from cal", state_code, 8'h01);
    autocal_mode = 2'b01; fire(0, 0, 0, 1);
    cal_done = 1; step(); cal_done = 0;
    fire(0, 1, 0, 0);
    chk("R8 idle from boost", state_code, 8'h01);
    step();
    chk("R8 stays idle", state_code, 8'h01);
    go_xmit();
    fire(0, 1, 0, 0);
    chk("R8 idle from xmit", state_code, 8'h01);
    go_starved();
    fire(0, 1, 0, 0);
    chk("R8 idle from underflow", state_code, 8'h01);
  endtask

  task automatic t_flush_gate();
    fire(0, 0, 1, 0);
    chk("R7 flush idle code", state_code, 8'h01);
    chk("R7 flush idle pulse", fifo_flush, 1);
    go_xmit();
    fire(0, 0, 1, 0);
    chk("R7 flush xmit code", state_code, 8'h13);
    chk("R7 flush xmit pulse", fifo_flush, 0);
    fire(0, 1, 0, 0);
  endtask

  task automatic t_priority();
    go_xmit();
    fire(1, 0, 0, 0);
    chk("R9 reset from xmit", state_code, 8'h01);
    autocal_mode = 2'b00;
    fire(0, 0, 1, 1);
    chk("R9 flush beats xmit code", state_code, 8'h01);
    chk("R9 flush beats xmit pulse", fifo_flush, 1);
    go_starved();
    fire(0, 1, 1, 0);
    chk("R9 idle beats flush code", state_code, 8'h01);
    chk("R9 idle beats flush pulse", fifo_flush, 0);
    fire(1, 0, 0, 1);
    chk("R9 reset beats xmit", state_code, 8'h01);
    go_synth(2'b00);
    fire(0, 1, 0, 1);
    chk("R9 idle beats xmit", state_code, 8'h01);
    autocal_mode = 2'b01; fire(0, 0, 0, 1);
    fire(1, 0, 0, 0);
    chk("R9 reset from cal", state_code, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset_state();
    t_cal_path();
    t_skip_cal();
    t_idle_abort();
    t_flush_gate();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule